// File: doc/BRIEF.md
# Method Write Burst Emitter

This block sits behind a small command processor. It collects outgoing register-write commands and sends them out as a stream of byte address and data pairs. The processor first gives a header word. The header names a starting method word address and a per-word stride. The processor then gives up to `DEPTH` data words. The block holds those words and sends none of them until something forces a release. On a release, each held word goes out with its own byte address, and the address moves forward by the stride after every word.

A release happens in three cases: a new header arrives while words are pending, the processor raises `flush_req`, or the processor is about to read state, reach a barrier or end its program. For the last group it also raises `flush_req`. During a release the block lowers `in_ready` and presents one pair per cycle on a valid/ready output. Two sticky flags record misuse: a data word with no header, and a data word beyond the buffer depth.

Top module: `mthd_emitter`

## Requirements
- R1: The byte address of the first word of a burst is header bits 11:0 shifted left by two.
- R2: The stride is header bits 15:12. After each emitted word the address grows by stride times four, modulo 2^14.
- R3: Up to `DEPTH` (default 8) data words are held behind one header. They are emitted in arrival order with the data unchanged.
- R4: A header accepted while words are pending first emits all of those words under the old header. The new header then takes effect with zero words pending.
- R5: An accepted `flush_req` emits all pending words. Afterwards no header is held, so a following data word raises `err_orphan`.
- R6: A flush with no header held, or with a header but no pending words, produces no output.
- R7: While emitting, `in_ready` is 0 and `out_valid` is 1. One pair leaves per cycle with `out_ready` high. With `out_ready` low, `out_addr` and `out_data` hold steady.
- R8: A data word accepted while no header is held is dropped, and `err_orphan` goes to 1 and stays there until reset.
- R9: A data word accepted with `DEPTH` words already pending is dropped, and `err_overflow` goes to 1 and stays there until reset.
- R10: If several strobes arrive in one cycle, a header wins over a flush, and a flush wins over a data word. The losing strobes are ignored.
- R11: After reset, `in_ready` is 1, `out_valid` is 0, both error flags are 0 and no header is held.
- R12: A header accepted with no words pending replaces the held header without producing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header strobe |
| hdr_word | input | 32 | Header word (bits 11:0 word address, bits 15:12 stride) |
| dat_valid | input | 1 | Data strobe |
| dat_word | input | 32 | Data word |
| flush_req | input | 1 | Release request (state read, barrier, program end) |
| in_ready | output | 1 | Strobes are taken only while high |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts the pair |
| out_addr | output | 14 | Byte address of the pair |
| out_data | output | 32 | Data of the pair |
| err_overflow | output | 1 | Sticky: word dropped because the buffer was full |
| err_orphan | output | 1 | Sticky: word dropped because no header was held |

## Verification
A behavioural queue model runs in parallel with the block, and every output is compared with it on every cycle. The test sequences cover these cases:
- A plain burst with stride one, which checks the address decode.
- A burst whose address wraps past the top of the 14-bit space while output is stalled. This separates correct stride arithmetic and output hold from a design that advances on its own.
- A header that overtakes pending words, which shows that old words keep the old header.
- Back-to-back headers with nothing pending, which must stay silent.
- A nine-word run, which proves the ninth word is dropped rather than overwriting the eighth.
- Header, flush and data strobes in the same cycle, which pins down the priority order.

// File: rtl/mthd_emit_pkg.sv
package mthd_emit_pkg;

   localparam int HDR_WADDR_W = 12;
   localparam int HDR_INC_LSB = 12;
   localparam int HDR_INC_W   = 4;
   localparam int HDR_USED_W  = HDR_INC_LSB + HDR_INC_W;

   typedef struct packed {
      logic [HDR_INC_W-1:0]   inc;
      logic [HDR_WADDR_W-1:0] waddr;
   } hdr_t;

   function automatic hdr_t decode_hdr(input logic [HDR_USED_W-1:0] w);
      hdr_t h;
      h.waddr = w[HDR_WADDR_W-1:0];
      h.inc   = w[HDR_INC_LSB +: HDR_INC_W];
      return h;
   endfunction

endpackage

// File: rtl/mthd_emit_store.sv
module mthd_emit_store #(
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IW'(i)) slot_q <= wr_data;
      end
      assign ent[i] = slot_q;
   end

   assign rd_data = ent[rd_idx];

endmodule

// File: rtl/mthd_emit_addr.sv
module mthd_emit_addr #(
   parameter int ADDR_W  = 14,
   parameter int WADDR_W = 12,
   parameter int INC_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [WADDR_W-1:0] load_waddr,
   input  logic [INC_W-1:0]   load_inc,
   input  logic               step,
   output logic [ADDR_W-1:0]  addr,
   output logic [INC_W-1:0]   inc
);

   if (ADDR_W != WADDR_W + 2) begin : g_bad_width
      $error("ADDR_W must equal WADDR_W + 2");
   end
   if (ADDR_W < INC_W + 2) begin : g_bad_inc
      $error("ADDR_W too narrow for stride");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [INC_W-1:0]  inc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         inc_q  <= '0;
      end else if (load) begin
         addr_q <= {load_waddr, 2'b00};
         inc_q  <= load_inc;
      end else if (step) begin
         addr_q <= addr_q + ADDR_W'({inc_q, 2'b00});
      end
   end

   assign addr = addr_q;
   assign inc  = inc_q;

endmodule

// File: rtl/mthd_emitter.sv
module mthd_emitter
   import mthd_emit_pkg::*;
#(
   parameter int DW     = 32,
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [31:0]       hdr_word,
   input  logic              dat_valid,
   input  logic [DW-1:0]     dat_word,
   input  logic              flush_req,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DW-1:0]     out_data,
   output logic              err_overflow,
   output logic              err_orphan
);

   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (ADDR_W != HDR_WADDR_W + 2) begin : g_bad_addr
      $error("ADDR_W must be header address width plus 2");
   end

   logic          held_q, drain_q, pend_q;
   logic [CW-1:0] cnt_q;
   logic [IW-1:0] rd_q;
   hdr_t          pend_hdr_q;
   logic          ovf_q, orph_q;

   hdr_t new_hdr;
   logic unused_hdr_hi;
   assign new_hdr       = decode_hdr(hdr_word[HDR_USED_W-1:0]);
   assign unused_hdr_hi = ^hdr_word[31:HDR_USED_W];

   logic accept, hdr_take, fl_take, dat_take, has_words, fire, last, wr_en;
   assign accept    = !drain_q;
   assign hdr_take  = accept && hdr_valid;
   assign fl_take   = accept && flush_req && !hdr_valid;
   assign dat_take  = accept && dat_valid && !hdr_valid && !flush_req;
   assign has_words = held_q && (cnt_q != '0);
   assign fire      = drain_q && out_ready;
   assign last      = fire && (CW'(rd_q) + CW'(1) == cnt_q);
   assign wr_en     = dat_take && held_q && (cnt_q != CW'(DEPTH));

   logic [ADDR_W-1:0]      cur_addr;
   logic [HDR_INC_W-1:0]   cur_inc;
   logic                   ld;
   logic [HDR_WADDR_W-1:0] ld_waddr;
   logic [HDR_INC_W-1:0]   ld_inc;

   assign ld       = (hdr_take && !has_words) || (last && pend_q);
   assign ld_waddr = hdr_take ? new_hdr.waddr : pend_hdr_q.waddr;
   assign ld_inc   = hdr_take ? new_hdr.inc   : pend_hdr_q.inc;

   mthd_emit_addr #(
      .ADDR_W (ADDR_W),
      .WADDR_W(HDR_WADDR_W),
      .INC_W  (HDR_INC_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_waddr(ld_waddr),
      .load_inc  (ld_inc),
      .step      (fire),
      .addr      (cur_addr),
      .inc       (cur_inc)
   );

   mthd_emit_store #(
      .DW   (DW),
      .DEPTH(DEPTH)
   ) u_store (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_idx (IW'(cnt_q)),
      .wr_data(dat_word),
      .rd_idx (rd_q),
      .rd_data(out_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q     <= 1'b0;
         drain_q    <= 1'b0;
         pend_q     <= 1'b0;
         pend_hdr_q <= '0;
         cnt_q      <= '0;
         rd_q       <= '0;
         ovf_q      <= 1'b0;
         orph_q     <= 1'b0;
      end else if (drain_q) begin
         if (last) begin
            drain_q <= 1'b0;
            cnt_q   <= '0;
            rd_q    <= '0;
            held_q  <= pend_q;
            pend_q  <= 1'b0;
         end else if (fire) begin
            rd_q <= rd_q + IW'(1);
         end
      end else if (hdr_take) begin
         if (has_words) begin
            drain_q    <= 1'b1;
            pend_q     <= 1'b1;
            pend_hdr_q <= new_hdr;
            rd_q       <= '0;
         end else begin
            held_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (fl_take) begin
         if (has_words) begin
            drain_q <= 1'b1;
            rd_q    <= '0;
         end else begin
            held_q <= 1'b0;
            cnt_q  <= '0;
         end
      end else if (dat_take) begin
         if (!held_q)                     orph_q <= 1'b1;
         else if (cnt_q == CW'(DEPTH))    ovf_q  <= 1'b1;
         else                             cnt_q  <= cnt_q + CW'(1);
      end
   end

   assign in_ready     = !drain_q;
   assign out_valid    = drain_q;
   assign out_addr     = cur_addr;
   assign err_overflow = ovf_q;
   assign err_orphan   = orph_q;

   logic [ADDR_W-1:0] stride;
   assign stride = ADDR_W'({cur_inc, 2'b00});

   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));

   a_r2_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !last |=> out_addr == $past(out_addr) + $past(stride));

   a_r6_silent_flush: assert property (@(posedge clk) disable iff (!rst_n)
      fl_take && !held_q |=> !out_valid);

   a_r8_orphan_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_orphan |=> err_orphan);

   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |=> err_overflow);

   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

endmodule

// File: tb/mthd_emitter_test.sv
module mthd_emitter_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0, dat_valid = 1'b0, flush_req = 1'b0, out_ready = 1'b1;
   logic [31:0] hdr_word = '0, dat_word = '0;
   logic        in_ready, out_valid, err_overflow, err_orphan;
   logic [13:0] out_addr;
   logic [31:0] out_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   mthd_emitter uut (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_word(hdr_word),
      .dat_valid(dat_valid), .dat_word(dat_word),
      .flush_req(flush_req), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_data(out_data),
      .err_overflow(err_overflow), .err_orphan(err_orphan)
   );

   int n_run = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   int unsigned m_q[$];
   bit m_held, m_drain, m_pend, m_ovf, m_orph;
   int unsigned m_addr, m_inc, m_paddr, m_pinc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         m_held = 0; m_drain = 0; m_pend = 0; m_ovf = 0; m_orph = 0;
         m_addr = 0; m_inc = 0;
      end else if (m_drain) begin
         if (out_ready) begin
            void'(m_q.pop_front());
            m_addr = (m_addr + m_inc * 4) & 'h3fff;
            if (m_q.size() == 0) begin
               m_drain = 0;
               m_held = m_pend;
               if (m_pend) begin m_addr = m_paddr; m_inc = m_pinc; end
               m_pend = 0;
            end
         end
      end else if (hdr_valid) begin
         if (m_held && m_q.size() > 0) begin
            m_drain = 1; m_pend = 1;
            m_paddr = (hdr_word & 'hfff) * 4; m_pinc = (hdr_word >> 12) & 'hf;
         end else begin
            m_held = 1; m_addr = (hdr_word & 'hfff) * 4; m_inc = (hdr_word >> 12) & 'hf;
         end
      end else if (flush_req) begin
         if (m_held && m_q.size() > 0) m_drain = 1;
         else m_held = 0;
      end else if (dat_valid) begin
         if (!m_held) m_orph = 1;
         else if (m_q.size() == 8) m_ovf = 1;
         else m_q.push_back(dat_word);
      end
   end

   logic [45:0] got[$];

   always @(negedge clk) begin
      if (rst_n) begin
         chk(out_valid == m_drain, "R7 out_valid", 64'(out_valid), 64'(m_drain));
         chk(in_ready == !m_drain, "R7 in_ready", 64'(in_ready), 64'(!m_drain));
         if (m_drain && out_valid) begin
            chk(out_addr == m_addr[13:0], "R2 address", 64'(out_addr), 64'(m_addr));
            chk(out_data == m_q[0], "R3 data", 64'(out_data), 64'(m_q[0]));
         end
         chk(err_overflow == m_ovf, "R9 overflow flag", 64'(err_overflow), 64'(m_ovf));
         chk(err_orphan == m_orph, "R8 orphan flag", 64'(err_orphan), 64'(m_orph));
         if (out_valid && out_ready) got.push_back({out_addr, out_data});
      end
   end

   task automatic strobe(input bit hv, input logic [31:0] hw, input bit dv,
                         input logic [31:0] dw, input bit fl);
      while (!in_ready) begin @(posedge clk); #1; end
      hdr_valid = hv; hdr_word = hw; dat_valid = dv; dat_word = dw; flush_req = fl;
      @(posedge clk); #1;
      hdr_valid = 0; dat_valid = 0; flush_req = 0;
   endtask

   task automatic hdr(input logic [31:0] w); strobe(1, w, 0, 0, 0); endtask
   task automatic dat(input logic [31:0] w); strobe(0, 0, 1, w, 0); endtask
   task automatic flush(); strobe(0, 0, 0, 0, 1); endtask
   task automatic settle(); repeat (12) @(posedge clk); #1; endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(in_ready == 1 && out_valid == 0, "R11 reset ready/valid", {in_ready, out_valid}, 2'b10);
      chk(err_overflow == 0 && err_orphan == 0, "R11 reset flags", {err_overflow, err_orphan}, 0);
      rst_n = 1;
      @(posedge clk); #1;

      // plain burst, stride 1
      got.delete();
      hdr(32'h0000_1010);
      dat(32'hA0); dat(32'hA1); dat(32'hA2);
      flush();
      settle();
      chk(got.size() == 3, "R5 flush count", got.size(), 3);
      if (got.size() == 3) begin
         chk(got[0][45:32] == 14'h40, "R1 first address", got[0][45:32], 14'h40);
         chk(got[2] == {14'h48, 32'hA2}, "R3 order", got[2], {14'h48, 32'hA2});
      end

      // wrap with stall, header overtakes pending words
      got.delete();
      hdr(32'h0000_2FFF);
      dat(32'hB0); dat(32'hB1);
      out_ready = 0;
      hdr(32'h0000_0020);
      repeat (3) @(posedge clk); #1;
      chk(out_valid == 1 && in_ready == 0, "R7 stalled drain", {out_valid, in_ready}, 2'b10);
      chk(out_addr == 14'h3FFC, "R7 hold address", out_addr, 14'h3FFC);
      out_ready = 1;
      settle();
      dat(32'hC0); dat(32'hC1);
      flush();
      settle();
      chk(got.size() == 4, "R4 burst count", got.size(), 4);
      if (got.size() == 4) begin
         chk(got[1] == {14'h0004, 32'hB1}, "R2 wrap", got[1], {14'h0004, 32'hB1});
         chk(got[2] == {14'h0080, 32'hC0}, "R4 new header", got[2], {14'h0080, 32'hC0});
         chk(got[3] == {14'h0080, 32'hC1}, "R4 zero stride", got[3], {14'h0080, 32'hC1});
      end

      // header replacement without pending words
      got.delete();
      hdr(32'h0000_1100); hdr(32'h0000_1200);
      settle();
      chk(got.size() == 0, "R12 silent replace", got.size(), 0);
      dat(32'hD0);
      flush();
      settle();
      chk(got.size() == 1 && got[0][45:32] == 14'h0800, "R12 replaced address",
          (got.size() > 0) ? 64'(got[0][45:32]) : 64'hdead, 14'h0800);

      // flushes that must stay silent
      got.delete();
      flush();
      hdr(32'h0000_1700);
      flush();
      settle();
      chk(got.size() == 0, "R6 silent flush", got.size(), 0);

      // overflow
      got.delete();
      hdr(32'h0000_1000);
      for (int i = 0; i < 9; i++) dat(32'hE0 + i);
      chk(err_overflow == 1, "R9 overflow raised", err_overflow, 1);
      flush();
      settle();
      chk(got.size() == 8, "R9 ninth dropped", got.size(), 8);
      if (got.size() == 8)
         chk(got[7] == {14'h001C, 32'hE7}, "R3 last held word", got[7], {14'h001C, 32'hE7});

      // simultaneous strobes
      got.delete();
      hdr(32'h0000_1300);
      dat(32'hF0);
      strobe(1, 32'h0000_1400, 1, 32'hF1, 1);
      settle();
      chk(got.size() == 1 && got[0] == {14'h0C00, 32'hF0}, "R10 header wins",
          (got.size() > 0) ? 64'(got[0]) : 64'hdead, {14'h0C00, 32'hF0});
      dat(32'hF2);
      flush();
      settle();
      chk(got.size() == 2 && got[1] == {14'h1000, 32'hF2}, "R10 data ignored",
          (got.size() > 1) ? 64'(got[1]) : 64'hdead, {14'h1000, 32'hF2});

      // data after flush has no header
      chk(err_orphan == 0, "R8 orphan clear before", err_orphan, 0);
      dat(32'h0BAD);
      chk(err_orphan == 1, "R5 header cleared by flush", err_orphan, 1);
      settle();
      chk(err_orphan == 1 && out_valid == 0, "R8 orphan sticky", {err_orphan, out_valid}, 2'b10);

      finish_up();
   end

endmodule